// File: doc/BRIEF.md
# Exception Entry Frame Sequencer

This block builds the stack frame that a processor core writes when it enters an exception handler. A single-cycle request carries the vector number, a summary of that vector's gate (present flag, slot width and handler privilege level) and a snapshot of the interrupted state: privilege level, flags, code selector, instruction pointer, stack selector and stack pointer. The block also takes the summary of the general-protection gate, the stack to switch to on a privilege change, the error code supplied by the faulting unit and an "external event" flag.

From these inputs the block works out four things. It picks the vector that is really taken. It decides whether an error code belongs in the frame, whether the stack must be switched, and how wide every slot is. It then issues one word write per cycle on a plain write port. Each write first moves the stack pointer down by the slot size and then stores at the new pointer. One cycle after the last write it pulses a done strobe carrying the final stack pointer, the final stack selector and the vector that was taken, so the core can fetch the handler. Descriptor fetch, limit checks and restart of the faulting instruction stay with the surrounding logic. Addresses are flat: the stack pointer value is the byte address.

Top module: `exc_frame_seq`

## Requirements
- R1: An error code slot is written only when the effective vector is 0x08, 0x0A, 0x0B, 0x0C, 0x0D or 0x0E. Every other vector (0x00 to 0xFF) writes no error code slot.
- R2: When gate_present is 0, the event is taken as vector 0x0D. In that case the slot width and handler level come from gp_is32 and gp_dpl. The error code written is then: bits 15..3 = requested vector, bit 2 = 0 (global table), bit 1 = 1 (gate entry), bit 0 = req_ext.
- R3: The frame is written in this order: flags, code selector, instruction pointer, and then the error code when R1 asks for one.
- R4: When the handler level differs from cur_cpl, writing starts from new_sp instead of cur_sp. Two slots are written before the flags: first cur_ss, then cur_sp. done_ss then reports new_ss. Without a change, done_ss reports cur_ss.
- R5: With a 32-bit gate, every slot is a 32-bit word and wr_size32 = 1. Selectors are zero-extended to 32 bits. With a 16-bit gate, wr_size32 = 0 and each slot carries the low 16 bits of the item in wr_data[15:0], with wr_data[31:16] = 0.
- R6: Each write address equals the previous stack pointer minus the slot size (4 or 2). The first write is at the start pointer minus the slot size.
- R7: The first write appears in the cycle after the request is accepted. Writes follow on consecutive cycles. done is high for exactly one cycle, the cycle after the last write. In that cycle done_sp equals the last write address and done_vector equals the effective vector.
- R8: A request raised while busy is high has no effect. It does not change the frame in progress, and no frame follows it.
- R9: After reset, busy, wr_en and done are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Exception request, taken when busy is low |
| req_vector | input | 8 | Requested vector number |
| req_err | input | 16 | Error code from the faulting unit |
| req_ext | input | 1 | Event came from outside the core |
| gate_present | input | 1 | Gate of the requested vector is present |
| gate_is32 | input | 1 | Gate of the requested vector uses 32-bit slots |
| gate_dpl | input | 2 | Handler privilege level of the requested gate |
| gp_is32 | input | 1 | General-protection gate uses 32-bit slots |
| gp_dpl | input | 2 | Handler privilege level of the general-protection gate |
| cur_cpl | input | 2 | Current privilege level |
| cur_flags | input | 32 | Current flags register |
| cur_cs | input | 16 | Current code selector |
| cur_ip | input | 32 | Instruction pointer of the faulting instruction |
| cur_ss | input | 16 | Current stack selector |
| cur_sp | input | 32 | Current stack pointer |
| new_ss | input | 16 | Handler stack selector on a privilege change |
| new_sp | input | 32 | Handler stack pointer on a privilege change |
| busy | output | 1 | Sequencer is writing a frame or signalling done |
| wr_en | output | 1 | Frame word write strobe |
| wr_addr | output | 32 | Byte address of the write |
| wr_data | output | 32 | Write data |
| wr_size32 | output | 1 | 1 = 32-bit slot, 0 = 16-bit slot |
| done | output | 1 | One-cycle handler entry strobe |
| done_sp | output | 32 | Final stack pointer |
| done_ss | output | 16 | Final stack selector |
| done_vector | output | 8 | Effective vector taken |

## Verification
Two things can happen in the same cycle: a new request arriving, and the sequencer still writing a frame or pulsing done. The bench provokes this by holding req_valid high, with a different vector, from the first write through the done cycle. It then judges the outcome by comparing every write and the done values with the unchanged expected frame, and by confirming that the port goes quiet afterwards. A second overlap is a missing gate combined with a privilege change. Here the redirect, the substituted error code and the stack switch all act on one frame. The bench checks them together against the independently computed layout, over every vector from 0x00 to 0x1F, both slot widths, and with and without a level change.

// File: rtl/exc_frame_pkg.sv
// Package: shared constants and types of the exception frame sequencer.
// Assumes: slot indices below define the write order of a frame.
package exc_frame_pkg;
    localparam int NSLOT     = 6;
    localparam int SLOT_OSS  = 0;
    localparam int SLOT_OSP  = 1;
    localparam int SLOT_FLG  = 2;
    localparam int SLOT_CS   = 3;
    localparam int SLOT_IP   = 4;
    localparam int SLOT_ERR  = 5;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PUSH = 2'd1,
        ST_DONE = 2'd2
    } seq_state_e;
endpackage

// File: rtl/exc_vec_decode.sv
// Module: resolves the effective vector, the gate attributes in force,
// whether an error code belongs in the frame, its value, and whether the
// privilege level changes.
// Assumes: VEC_W >= 5 and VEC_W + 3 <= EC_W; ERR_MAP bit n set means
// vector n (n < 32) carries an error code.
module exc_vec_decode #(
    parameter int          VEC_W   = 8,
    parameter int          PL_W    = 2,
    parameter int          EC_W    = 16,
    parameter logic [31:0] ERR_MAP = 32'h0000_7D00,
    parameter int          GP_VEC  = 13
) (
    input  logic [VEC_W-1:0] vector,
    input  logic             present,
    input  logic             g_is32,
    input  logic [PL_W-1:0]  g_dpl,
    input  logic             gp_is32,
    input  logic [PL_W-1:0]  gp_dpl,
    input  logic [PL_W-1:0]  cpl,
    input  logic             ext,
    input  logic [EC_W-1:0]  err_in,
    output logic [VEC_W-1:0] eff_vec,
    output logic             has_err,
    output logic [EC_W-1:0]  err_out,
    output logic             is32,
    output logic             priv_chg
);
    localparam int LOW_W = 5;

    logic [PL_W-1:0] dpl_sel;
    logic [EC_W-1:0] gp_code;

    // Purpose: pick the gate actually used and the effective vector.
    always_comb begin
        eff_vec = present ? vector : VEC_W'(GP_VEC);
        is32    = present ? g_is32 : gp_is32;
        dpl_sel = present ? g_dpl  : gp_dpl;
        priv_chg = (dpl_sel != cpl);
    end

    // Purpose: build the general-protection code for a missing gate.
    always_comb begin
        gp_code            = '0;
        gp_code[3 +: VEC_W] = vector;
        gp_code[1]         = 1'b1;
        gp_code[0]         = ext;
    end

    // Purpose: decide error code presence and its value.
    always_comb begin
        has_err = ((eff_vec >> LOW_W) == '0) && ERR_MAP[eff_vec[LOW_W-1:0]];
        err_out = present ? err_in : gp_code;
    end
endmodule

// File: rtl/exc_slot_build.sv
// Module: lays out the candidate frame slots, formatted to the slot width,
// and a mask of the slots that belong in this frame.
// Assumes: DW is even; narrow slots keep the low DW/2 bits.
module exc_slot_build
    import exc_frame_pkg::*;
#(
    parameter int DW    = 32,
    parameter int SEL_W = 16,
    parameter int EC_W  = 16
) (
    input  logic             is32,
    input  logic             priv_chg,
    input  logic             has_err,
    input  logic [DW-1:0]    flags,
    input  logic [SEL_W-1:0] cs,
    input  logic [DW-1:0]    ip,
    input  logic [SEL_W-1:0] old_ss,
    input  logic [DW-1:0]    old_sp,
    input  logic [EC_W-1:0]  err,
    output logic [DW-1:0]    slot_data [NSLOT],
    output logic [NSLOT-1:0] slot_mask
);
    localparam int HW = DW / 2;

    logic [DW-1:0] raw [NSLOT];

    // Purpose: gather the raw items in write order, selectors zero-extended.
    always_comb begin
        raw[SLOT_OSS] = DW'(old_ss);
        raw[SLOT_OSP] = old_sp;
        raw[SLOT_FLG] = flags;
        raw[SLOT_CS]  = DW'(cs);
        raw[SLOT_IP]  = ip;
        raw[SLOT_ERR] = DW'(err);
    end

    // Purpose: select which slots this frame writes.
    always_comb begin
        slot_mask           = '0;
        slot_mask[SLOT_OSS] = priv_chg;
        slot_mask[SLOT_OSP] = priv_chg;
        slot_mask[SLOT_FLG] = 1'b1;
        slot_mask[SLOT_CS]  = 1'b1;
        slot_mask[SLOT_IP]  = 1'b1;
        slot_mask[SLOT_ERR] = has_err;
    end

    // Purpose: trim each slot to the gate width.
    for (genvar g = 0; g < NSLOT; g++) begin : g_fmt
        assign slot_data[g] = is32 ? raw[g] : {{(DW-HW){1'b0}}, raw[g][HW-1:0]};
    end
endmodule

// File: rtl/exc_slot_cursor.sv
// Module: finds the lowest set mask bit at or above a starting index.
// Assumes: start may equal NSLOT, meaning nothing is left.
module exc_slot_cursor #(
    parameter int NSLOT = 6,
    localparam int IDX_W = $clog2(NSLOT)
) (
    input  logic [NSLOT-1:0] mask,
    input  logic [IDX_W:0]   start,
    output logic             found,
    output logic [IDX_W-1:0] idx
);
    // Purpose: downward scan so the lowest qualifying index wins.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = NSLOT - 1; i >= 0; i--) begin
            if (mask[i] && (i >= int'(start))) begin
                found = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/exc_frame_seq.sv
// Module: exception entry frame sequencer top. Accepts a request while
// idle, latches the laid-out frame, writes one slot per cycle with
// pre-decrement addressing, then strobes done for one cycle.
// Assumes: flat stack addressing; request inputs are valid with req_valid.
module exc_frame_seq
    import exc_frame_pkg::*;
#(
    parameter int VEC_W = 8,
    parameter int PL_W  = 2,
    parameter int SEL_W = 16,
    parameter int DW    = 32,
    parameter int EC_W  = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [VEC_W-1:0] req_vector,
    input  logic [EC_W-1:0]  req_err,
    input  logic             req_ext,
    input  logic             gate_present,
    input  logic             gate_is32,
    input  logic [PL_W-1:0]  gate_dpl,
    input  logic             gp_is32,
    input  logic [PL_W-1:0]  gp_dpl,
    input  logic [PL_W-1:0]  cur_cpl,
    input  logic [DW-1:0]    cur_flags,
    input  logic [SEL_W-1:0] cur_cs,
    input  logic [DW-1:0]    cur_ip,
    input  logic [SEL_W-1:0] cur_ss,
    input  logic [DW-1:0]    cur_sp,
    input  logic [SEL_W-1:0] new_ss,
    input  logic [DW-1:0]    new_sp,
    output logic             busy,
    output logic             wr_en,
    output logic [DW-1:0]    wr_addr,
    output logic [DW-1:0]    wr_data,
    output logic             wr_size32,
    output logic             done,
    output logic [DW-1:0]    done_sp,
    output logic [SEL_W-1:0] done_ss,
    output logic [VEC_W-1:0] done_vector
);
    localparam int IDX_W = $clog2(NSLOT);
    localparam logic [DW-1:0] STEP_W = DW'(4);
    localparam logic [DW-1:0] STEP_H = DW'(2);

    seq_state_e       state_q;
    logic [DW-1:0]    slot_q [NSLOT];
    logic [NSLOT-1:0] mask_q;
    logic [IDX_W-1:0] idx_q;
    logic [DW-1:0]    sp_q;
    logic [SEL_W-1:0] ss_q;
    logic [VEC_W-1:0] vec_q;
    logic             is32_q;

    logic [VEC_W-1:0] d_vec;
    logic             d_err, d_is32, d_chg;
    logic [EC_W-1:0]  d_code;
    logic [DW-1:0]    b_data [NSLOT];
    logic [NSLOT-1:0] b_mask;
    logic             f_found, n_found;
    logic [IDX_W-1:0] f_idx, n_idx;
    logic             accept;
    logic [DW-1:0]    step;

    exc_vec_decode #(.VEC_W(VEC_W), .PL_W(PL_W), .EC_W(EC_W)) u_dec (
        .vector(req_vector), .present(gate_present), .g_is32(gate_is32),
        .g_dpl(gate_dpl), .gp_is32(gp_is32), .gp_dpl(gp_dpl), .cpl(cur_cpl),
        .ext(req_ext), .err_in(req_err), .eff_vec(d_vec), .has_err(d_err),
        .err_out(d_code), .is32(d_is32), .priv_chg(d_chg)
    );

    exc_slot_build #(.DW(DW), .SEL_W(SEL_W), .EC_W(EC_W)) u_build (
        .is32(d_is32), .priv_chg(d_chg), .has_err(d_err), .flags(cur_flags),
        .cs(cur_cs), .ip(cur_ip), .old_ss(cur_ss), .old_sp(cur_sp),
        .err(d_code), .slot_data(b_data), .slot_mask(b_mask)
    );

    exc_slot_cursor #(.NSLOT(NSLOT)) u_first (
        .mask(b_mask), .start('0), .found(f_found), .idx(f_idx)
    );

    exc_slot_cursor #(.NSLOT(NSLOT)) u_next (
        .mask(mask_q), .start({1'b0, idx_q} + 1'b1), .found(n_found), .idx(n_idx)
    );

    // Purpose: request acceptance and current slot step.
    always_comb begin
        accept = req_valid && (state_q == ST_IDLE) && f_found;
        step   = is32_q ? STEP_W : STEP_H;
    end

    // Purpose: sequencer state, frame latch and stack pointer tracking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            mask_q  <= '0;
            idx_q   <= '0;
            sp_q    <= '0;
            ss_q    <= '0;
            vec_q   <= '0;
            is32_q  <= 1'b0;
            for (int i = 0; i < NSLOT; i++) slot_q[i] <= '0;
        end else begin
            case (state_q)
                ST_IDLE: if (accept) begin
                    state_q <= ST_PUSH;
                    mask_q  <= b_mask;
                    idx_q   <= f_idx;
                    sp_q    <= d_chg ? new_sp : cur_sp;
                    ss_q    <= d_chg ? new_ss : cur_ss;
                    vec_q   <= d_vec;
                    is32_q  <= d_is32;
                    for (int i = 0; i < NSLOT; i++) slot_q[i] <= b_data[i];
                end
                ST_PUSH: begin
                    sp_q <= sp_q - step;
                    if (n_found) idx_q <= n_idx;
                    else         state_q <= ST_DONE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Purpose: drive the write port and the done strobe from state.
    always_comb begin
        busy        = (state_q != ST_IDLE);
        wr_en       = (state_q == ST_PUSH);
        wr_addr     = sp_q - step;
        wr_data     = slot_q[idx_q];
        wr_size32   = is32_q;
        done        = (state_q == ST_DONE);
        done_sp     = sp_q;
        done_ss     = ss_q;
        done_vector = vec_q;
    end
endmodule

// File: rtl/exc_frame_seq_chk.sv
// Module: protocol checker for the frame sequencer, bound to the top.
// Assumes: sampled on the rising clock, idle during reset.
module exc_frame_seq_chk #(
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          busy,
    input logic          wr_en,
    input logic [DW-1:0] wr_addr,
    input logic [DW-1:0] wr_data,
    input logic          wr_size32,
    input logic          done,
    input logic [DW-1:0] done_sp
);
    localparam int HW = DW / 2;

    AST_WR_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> busy); // R7
    AST_DONE_NO_WR: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !wr_en); // R7
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R7
    AST_DONE_AFTER_WR: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(wr_en)); // R7
    AST_DONE_SP: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> done_sp == $past(wr_addr)); // R7
    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && $past(wr_en)) |->
        wr_addr == $past(wr_addr) - (wr_size32 ? DW'(4) : DW'(2))); // R6
    AST_SIZE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && $past(wr_en)) |-> $stable(wr_size32)); // R5
    AST_NARROW_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_size32) |-> wr_data[DW-1:HW] == '0); // R5
endmodule

bind exc_frame_seq exc_frame_seq_chk #(.DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_size32(wr_size32), .done(done), .done_sp(done_sp)
);

// File: tb/test_exc_frame_seq.sv
// Bench: sweeps vectors 0x00..0x1F over both slot widths and with and
// without a level change, adds random user vectors, missing gates and
// requests raised while busy; expected frames come from bench functions.
module test_exc_frame_seq;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [7:0]  req_vector = '0;
    logic [15:0] req_err = '0;
    logic        req_ext = 1'b0;
    logic        gate_present = 1'b1, gate_is32 = 1'b1, gp_is32 = 1'b1;
    logic [1:0]  gate_dpl = '0, gp_dpl = '0, cur_cpl = '0;
    logic [31:0] cur_flags = '0, cur_ip = '0, cur_sp = '0, new_sp = '0;
    logic [15:0] cur_cs = '0, cur_ss = '0, new_ss = '0;
    logic        busy, wr_en, wr_size32, done;
    logic [31:0] wr_addr, wr_data, done_sp;
    logic [15:0] done_ss;
    logic [7:0]  done_vector;

    int n_checks = 0;
    int n_errors = 0;

    logic [31:0] e_addr [6];
    logic [31:0] e_data [6];
    string       e_tag  [6];
    int          e_n;
    logic [31:0] e_sp;
    logic [15:0] e_ss;
    logic [7:0]  e_vec;
    logic        e_sz;

    always #(CLK_PERIOD/2) clk = ~clk;

    exc_frame_seq i_exc_frame_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vector(req_vector),
        .req_err(req_err), .req_ext(req_ext), .gate_present(gate_present),
        .gate_is32(gate_is32), .gate_dpl(gate_dpl), .gp_is32(gp_is32),
        .gp_dpl(gp_dpl), .cur_cpl(cur_cpl), .cur_flags(cur_flags),
        .cur_cs(cur_cs), .cur_ip(cur_ip), .cur_ss(cur_ss), .cur_sp(cur_sp),
        .new_ss(new_ss), .new_sp(new_sp), .busy(busy), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .wr_size32(wr_size32),
        .done(done), .done_sp(done_sp), .done_ss(done_ss),
        .done_vector(done_vector)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic bit vec_has_err(input logic [7:0] v);
        return v == 8'h08 || v == 8'h0A || v == 8'h0B || v == 8'h0C ||
               v == 8'h0D || v == 8'h0E;
    endfunction

    function automatic logic [31:0] fit(input logic [31:0] v, input bit w32);
        return w32 ? v : {16'h0, v[15:0]};
    endfunction

    // Expected frame from R1..R6.
    task automatic model();
        logic [1:0]  dpl;
        logic [15:0] code;
        logic [31:0] sp, step;
        logic [31:0] items [6];
        string       tags  [6];
        bit          chg;
        int          k = 0;
        e_vec = gate_present ? req_vector : 8'h0D;
        e_sz  = gate_present ? gate_is32 : gp_is32;
        dpl   = gate_present ? gate_dpl : gp_dpl;
        chg   = (dpl != cur_cpl);
        code  = gate_present ? req_err : {5'b0, req_vector, 1'b0, 1'b1, req_ext};
        if (chg) begin
            items[k] = {16'h0, cur_ss}; tags[k] = "R4 old ss"; k++;
            items[k] = cur_sp;          tags[k] = "R4 old sp"; k++;
        end
        items[k] = cur_flags;        tags[k] = "R3 flags"; k++;
        items[k] = {16'h0, cur_cs};  tags[k] = "R3 cs";    k++;
        items[k] = cur_ip;           tags[k] = "R3 ip";    k++;
        if (vec_has_err(e_vec)) begin
            items[k] = {16'h0, code};
            tags[k]  = gate_present ? "R1 err" : "R2 gp err";
            k++;
        end
        e_n  = k;
        step = e_sz ? 32'd4 : 32'd2;
        sp   = chg ? new_sp : cur_sp;
        e_ss = chg ? new_ss : cur_ss;
        for (int i = 0; i < k; i++) begin
            sp = sp - step;
            e_addr[i] = sp;
            e_data[i] = fit(items[i], e_sz);
            e_tag[i]  = tags[i];
        end
        e_sp = sp;
    endtask

    // Issue one request and check the whole frame; hold=1 keeps a
    // different request asserted while busy (R8).
    task automatic run(input logic [7:0] v, input bit pres, input bit g32,
                       input logic [1:0] gdpl, input logic [1:0] cpl, input bit hold);
        @(negedge clk);
        req_vector   = v;
        gate_present = pres;
        gate_is32    = g32;
        gate_dpl     = gdpl;
        cur_cpl      = cpl;
        gp_is32      = 1'($urandom);
        gp_dpl       = 2'($urandom);
        req_err      = 16'($urandom);
        req_ext      = 1'($urandom);
        cur_flags    = $urandom;
        cur_cs       = 16'($urandom);
        cur_ip       = $urandom;
        cur_ss       = 16'($urandom);
        cur_sp       = {$urandom, 2'b00} | 32'h0000_1000;
        new_ss       = 16'($urandom);
        new_sp       = {$urandom, 2'b00} | 32'h0000_1000;
        model();
        req_valid = 1'b1;
        @(negedge clk);
        if (hold) begin
            req_vector   = req_vector ^ 8'h05;
            gate_present = ~gate_present;
            gate_is32    = ~gate_is32;
            cur_sp       = cur_sp + 32'h40;
        end else begin
            req_valid = 1'b0;
        end
        for (int i = 0; i < e_n; i++) begin
            check(wr_en === 1'b1, "R7", "write strobe", {31'b0, wr_en}, 32'd1);
            check(wr_size32 === e_sz, "R5", "slot width", {31'b0, wr_size32}, {31'b0, e_sz});
            check(wr_addr === e_addr[i], "R6", "write address", wr_addr, e_addr[i]);
            check(wr_data === e_data[i], e_tag[i], "write data", wr_data, e_data[i]);
            @(negedge clk);
        end
        check(done === 1'b1 && wr_en === 1'b0, "R7", "done after last write",
              {30'b0, done, wr_en}, 32'd2);
        check(done_sp === e_sp, "R7", "done stack pointer", done_sp, e_sp);
        check(done_ss === e_ss, "R4", "done stack selector", {16'h0, done_ss}, {16'h0, e_ss});
        check(done_vector === e_vec, pres ? "R7" : "R2", "done vector",
              {24'h0, done_vector}, {24'h0, e_vec});
        req_valid = 1'b0;
        @(negedge clk);
        check(busy === 1'b0 && wr_en === 1'b0 && done === 1'b0,
              hold ? "R8" : "R7", "idle after frame",
              {29'b0, busy, wr_en, done}, 32'd0);
    endtask

    initial begin
        int seed;
        seed = $urandom(32'd20240611);
        repeat (3) @(negedge clk);
        check(busy === 1'b0 && wr_en === 1'b0 && done === 1'b0, "R9",
              "reset outputs", {29'b0, busy, wr_en, done}, 32'd0);
        rst_n = 1'b1;
        // Sweep: every low vector, both widths, same and different level.
        for (int v = 0; v < 32; v++)
            for (int w = 0; w < 2; w++)
                for (int c = 0; c < 2; c++)
                    run(8'(v), 1'b1, w[0], 2'(c * 3), 2'd0, 1'b0);
        // Missing gates with and without level change (R2).
        for (int v = 0; v < 32; v++) begin
            gp_dpl = 2'd0;
            run(8'(v), 1'b0, 1'b1, 2'd0, 2'(v & 3), 1'b0);
        end
        // Random user vectors never carry an error code (R1).
        for (int n = 0; n < 40; n++)
            run(8'h20 + 8'($urandom % 224), 1'b1, 1'($urandom),
                2'($urandom), 2'($urandom), 1'b0);
        // Requests raised while busy are ignored (R8).
        run(8'h0E, 1'b1, 1'b1, 2'd0, 2'd3, 1'b1);
        run(8'h03, 1'b1, 1'b0, 2'd1, 2'd1, 1'b1);
        run(8'hFF, 1'b0, 1'b0, 2'd2, 2'd0, 1'b1);
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule